// File: doc/BRIEF.md
# Clock Fan-Out Divider and Output Stage

This block is the digital back end of a clock fan-out driver. It takes a fast oscillator clock and two reference clocks and derives a family of related clocks from one source. The source is either the oscillator or, in bypass (test) mode, one of the two references chosen by a select pin. An optional divide-by-two stage sits in front of the double-rate clock. A chain of toggle registers then produces the other outputs: a group of identical base-rate clocks at half the double rate, one inverted base-rate clock, and one half-rate clock at half the base rate.

A single active-low pin serves as both output enable and reset. While it is low, every output is marked disabled and the base, inverted and half-rate registers are held in reset. Assertion of this reset is asynchronous. Its release is synchronised to the divider clock, so the first edges after release line up with an active double-rate edge. High impedance is modelled by an enable flag that travels with each clock output. In bypass mode the polarity of every clock output is inverted. A lock flag from the external oscillator loop is passed to the output.

Top module: `clkfan_drv`

## Requirements
- R1: In bypass mode (`osc_en_i` = 0), `ref_sel_i` = 0 makes `ref0_clk_i` the divider source and `ref_sel_i` = 1 makes `ref1_clk_i` the source.
- R2: `osc_en_i` = 1 makes `osc_clk_i` the divider source; `osc_en_i` = 0 makes the selected reference the source.
- R3: `rate_full_i` = 1 gives a double-rate output at the source frequency; `rate_full_i` = 0 gives a double-rate output at half the source frequency.
- R4: All NUM_BASE base-rate outputs are identical and run at half the double-rate frequency, changing only on an active double-rate edge.
- R5: The half-rate output runs at half the base-rate frequency and changes only on an active base-rate edge.
- R6: The inverted base-rate output is always the complement of the base-rate outputs.
- R7: In reset, the clock outputs rest at base = 0, inverted = 1, half = 0 when `osc_en_i` = 1, and at base = 1, inverted = 0, half = 1 when `osc_en_i` = 0 (every output polarity flipped in bypass).
- R8: While `oe_rst_n_i` = 0, all eight enable flags are 0 and the base, inverted and half-rate outputs hold their reset levels whatever the clocks do; while it is 1, all enable flags are 1.
- R9: After `oe_rst_n_i` rises, the first change of the base and half-rate outputs moves them to their active level (1 in normal mode, 0 in bypass). It happens in the same instant as an active double-rate edge, which is a rising edge in normal mode and a falling edge in bypass.
- R10: `lock_o` equals `lock_i` when `osc_en_i` = 1 and is 0 in bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock |
| ref0_clk_i | input | 1 | Reference clock, choice 0 |
| ref1_clk_i | input | 1 | Reference clock, choice 1 |
| ref_sel_i | input | 1 | Reference select (0: ref0, 1: ref1) |
| osc_en_i | input | 1 | 1: oscillator drives divider; 0: bypass with reference |
| rate_full_i | input | 1 | 1: double-rate = source; 0: double-rate = source / 2 |
| oe_rst_n_i | input | 1 | Output enable, and active-low asynchronous reset of the divider |
| lock_i | input | 1 | Lock flag from the external loop |
| dbl_clk_o | output | 1 | Double-rate clock |
| dbl_oe_o | output | 1 | Enable flag of dbl_clk_o |
| base_clk_o | output | NUM_BASE | Base-rate clocks |
| base_oe_o | output | NUM_BASE | Enable flags of base_clk_o |
| binv_clk_o | output | 1 | Inverted base-rate clock |
| binv_oe_o | output | 1 | Enable flag of binv_clk_o |
| half_clk_o | output | 1 | Half-rate clock |
| half_oe_o | output | 1 | Enable flag of half_clk_o |
| lock_o | output | 1 | Lock indication |

## Verification
The bench counts output edges over fixed windows in each combination of source and rate setting. A wrong reference or prescaler choice then shows up as a count off by a factor, not by one edge. It checks the reset levels in both polarities and watches that nothing moves while the enable pin is low, which catches a missing flip or a leaky hold. It also catches a release that is not synchronous to the divider clock: it tracks the first base and half-rate change after release and requires an active double-rate edge in the same instant, moving toward the active level.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/100ps
package clkfan_pkg;
  // Meaning of the reference select pin.
  typedef enum logic {REF_A = 1'b0, REF_B = 1'b1} ref_pick_e;
  // Meaning of the rate select pin.
  typedef enum logic {RATE_HALF = 1'b0, RATE_FULL = 1'b1} rate_e;
  // Outputs besides the base group: double-rate, inverted, half-rate.
  localparam int unsigned FIXED_OUTS = 3;
endpackage

// File: rtl/clkfan_clk_sel.sv
`timescale 1ns/100ps
// Source selection and optional divide-by-two in front of the divider chain.
module clkfan_clk_sel
  import clkfan_pkg::*;
(
  input  logic osc_clk_i,
  input  logic ref0_clk_i,
  input  logic ref1_clk_i,
  input  logic ref_sel_i,
  input  logic osc_en_i,
  input  logic rate_full_i,
  input  logic arst_n_i,
  output logic div_clk_o
);
  logic ref_clk;
  logic src_clk;
  logic pre_q;

  always_comb begin
    ref_clk = (ref_pick_e'(ref_sel_i) == REF_B) ? ref1_clk_i : ref0_clk_i;
    src_clk = osc_en_i ? osc_clk_i : ref_clk;
  end

  // Prescaler shares the pin reset so it starts from a known phase.
  always_ff @(posedge src_clk or negedge arst_n_i) begin
    if (!arst_n_i) pre_q <= 1'b0;
    else           pre_q <= ~pre_q;
  end

  always_comb div_clk_o = (rate_e'(rate_full_i) == RATE_FULL) ? src_clk : pre_q;
endmodule

// File: rtl/clkfan_rst_sync.sv
`timescale 1ns/100ps
// Asynchronous assertion, release synchronised to the divider clock.
module clkfan_rst_sync #(
  parameter int unsigned STAGES = 2   // must be at least 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/clkfan_div_chain.sv
`timescale 1ns/100ps
// Toggle registers for base, inverted and half-rate clocks, one clock domain.
module clkfan_div_chain #(
  parameter int unsigned NUM_BASE = 5
) (
  input  logic                clk_i,
  input  logic                rst_i,
  output logic [NUM_BASE-1:0] base_o,
  output logic                binv_o,
  output logic                half_o
);
  logic [NUM_BASE-1:0] base_q;
  logic                binv_q;
  logic                half_q;

  // One register per base output, as a fan-out driver would place them.
  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) base_q[g] <= 1'b0;
      else       base_q[g] <= ~base_q[g];
    end
  end

  // Inverted output has its own register that rests high.
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) binv_q <= 1'b1;
    else       binv_q <= ~binv_q;
  end

  // Half-rate toggles on the edge where the base clock rises.
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)           half_q <= 1'b0;
    else if (!base_q[0]) half_q <= ~half_q;
  end

  assign base_o = base_q;
  assign binv_o = binv_q;
  assign half_o = half_q;
endmodule

// File: rtl/clkfan_out_stage.sv
`timescale 1ns/100ps
// Polarity flip and enable flags for every clock output.
module clkfan_out_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic             flip_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] clk_o,
  output logic [WIDTH-1:0] oe_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_out
    assign clk_o[g] = raw_i[g] ^ flip_i;
    assign oe_o[g]  = en_i;
  end
endmodule

// File: rtl/clkfan_drv.sv
`timescale 1ns/100ps
module clkfan_drv
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_BASE    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                osc_clk_i,
  input  logic                ref0_clk_i,
  input  logic                ref1_clk_i,
  input  logic                ref_sel_i,
  input  logic                osc_en_i,
  input  logic                rate_full_i,
  input  logic                oe_rst_n_i,
  input  logic                lock_i,
  output logic                dbl_clk_o,
  output logic                dbl_oe_o,
  output logic [NUM_BASE-1:0] base_clk_o,
  output logic [NUM_BASE-1:0] base_oe_o,
  output logic                binv_clk_o,
  output logic                binv_oe_o,
  output logic                half_clk_o,
  output logic                half_oe_o,
  output logic                lock_o
);
  localparam int unsigned NUM_OUT  = NUM_BASE + FIXED_OUTS;
  localparam int unsigned IDX_DBL  = 0;
  localparam int unsigned IDX_BASE = 1;
  localparam int unsigned IDX_INV  = NUM_BASE + 1;
  localparam int unsigned IDX_HALF = NUM_BASE + 2;

  logic                div_clk;
  logic                div_rst;
  logic [NUM_BASE-1:0] base_raw;
  logic                inv_raw;
  logic                half_raw;
  logic [NUM_OUT-1:0]  raw_vec;
  logic [NUM_OUT-1:0]  clk_vec;
  logic [NUM_OUT-1:0]  oe_vec;

  clkfan_clk_sel u_sel (
    .osc_clk_i  (osc_clk_i),
    .ref0_clk_i (ref0_clk_i),
    .ref1_clk_i (ref1_clk_i),
    .ref_sel_i  (ref_sel_i),
    .osc_en_i   (osc_en_i),
    .rate_full_i(rate_full_i),
    .arst_n_i   (oe_rst_n_i),
    .div_clk_o  (div_clk)
  );

  clkfan_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (div_clk),
    .arst_n_i(oe_rst_n_i),
    .rst_o   (div_rst)
  );

  clkfan_div_chain #(.NUM_BASE(NUM_BASE)) u_chain (
    .clk_i (div_clk),
    .rst_i (div_rst),
    .base_o(base_raw),
    .binv_o(inv_raw),
    .half_o(half_raw)
  );

  assign raw_vec = {half_raw, inv_raw, base_raw, div_clk};

  clkfan_out_stage #(.WIDTH(NUM_OUT)) u_out (
    .raw_i (raw_vec),
    .flip_i(~osc_en_i),
    .en_i  (oe_rst_n_i),
    .clk_o (clk_vec),
    .oe_o  (oe_vec)
  );

  assign dbl_clk_o  = clk_vec[IDX_DBL];
  assign dbl_oe_o   = oe_vec[IDX_DBL];
  assign base_clk_o = clk_vec[IDX_INV-1:IDX_BASE];
  assign base_oe_o  = oe_vec[IDX_INV-1:IDX_BASE];
  assign binv_clk_o = clk_vec[IDX_INV];
  assign binv_oe_o  = oe_vec[IDX_INV];
  assign half_clk_o = clk_vec[IDX_HALF];
  assign half_oe_o  = oe_vec[IDX_HALF];

  // R10: lock is meaningless while the oscillator is bypassed.
  assign lock_o = lock_i & osc_en_i;
endmodule

// File: rtl/clkfan_chk.sv
`timescale 1ns/100ps
module clkfan_chk #(
  parameter int unsigned NUM_BASE = 5
) (
  input logic                  osc_clk_i,
  input logic                  div_clk,
  input logic                  div_rst,
  input logic                  osc_en_i,
  input logic                  oe_rst_n_i,
  input logic [NUM_BASE+2:0]   raw,
  input logic [NUM_BASE-1:0]   base_clk_o,
  input logic [NUM_BASE-1:0]   base_oe_o,
  input logic                  binv_clk_o,
  input logic                  half_clk_o,
  input logic                  dbl_oe_o,
  input logic                  half_oe_o
);
  localparam int unsigned B0   = 1;
  localparam int unsigned INV  = NUM_BASE + 1;
  localparam int unsigned HALF = NUM_BASE + 2;

  // R4
  base_same_chk: assert property (@(posedge div_clk) disable iff (div_rst)
    raw[INV-1:B0] == {NUM_BASE{raw[B0]}});

  // R4
  base_toggle_chk: assert property (@(posedge div_clk) disable iff (div_rst)
    oe_rst_n_i |=> raw[B0] != $past(raw[B0]));

  // R6
  inv_comp_chk: assert property (@(posedge div_clk) disable iff (div_rst)
    raw[INV] != raw[B0]);

  // R5
  half_step_chk: assert property (@(posedge div_clk) disable iff (div_rst)
    !raw[B0] |=> raw[HALF] != $past(raw[HALF]));

  // R5
  half_hold_chk: assert property (@(posedge div_clk) disable iff (div_rst)
    raw[B0] |=> $stable(raw[HALF]));

  // R8
  pin_hold_chk: assert property (@(posedge osc_clk_i)
    !oe_rst_n_i |-> div_rst && !dbl_oe_o && !half_oe_o && (base_oe_o == '0));

  // R7
  rest_level_chk: assert property (@(posedge osc_clk_i)
    div_rst |-> (base_clk_o[0] == !osc_en_i) && (binv_clk_o == osc_en_i)
                && (half_clk_o == !osc_en_i));
endmodule

bind clkfan_drv clkfan_chk #(.NUM_BASE(NUM_BASE)) u_chk (
  .osc_clk_i (osc_clk_i),
  .div_clk   (div_clk),
  .div_rst   (div_rst),
  .osc_en_i  (osc_en_i),
  .oe_rst_n_i(oe_rst_n_i),
  .raw       (raw_vec),
  .base_clk_o(base_clk_o),
  .base_oe_o (base_oe_o),
  .binv_clk_o(binv_clk_o),
  .half_clk_o(half_clk_o),
  .dbl_oe_o  (dbl_oe_o),
  .half_oe_o (half_oe_o)
);

// File: tb/sim_clkfan_drv.sv
`timescale 1ns/100ps
module sim_clkfan_drv;
  localparam int NB     = 5;
  localparam int OSC_P  = 4;    // 250 MHz
  localparam int REF0_P = 40;
  localparam int REF1_P = 56;
  localparam int WIN_NS = 2048;

  logic osc_clk = 1'b0, ref0_clk = 1'b0, ref1_clk = 1'b0;
  logic ref_sel, osc_en, rate_full, oe_rst_n, lock_in;
  logic dbl_clk, dbl_oe, binv_clk, binv_oe, half_clk, half_oe, lock_out;
  logic [NB-1:0] base_clk, base_oe;

  always #(OSC_P/2)  osc_clk  = ~osc_clk;
  always #(REF0_P/2) ref0_clk = ~ref0_clk;
  always #(REF1_P/2) ref1_clk = ~ref1_clk;

  clkfan_drv #(.NUM_BASE(NB)) u0 (
    .osc_clk_i(osc_clk), .ref0_clk_i(ref0_clk), .ref1_clk_i(ref1_clk),
    .ref_sel_i(ref_sel), .osc_en_i(osc_en), .rate_full_i(rate_full),
    .oe_rst_n_i(oe_rst_n), .lock_i(lock_in),
    .dbl_clk_o(dbl_clk), .dbl_oe_o(dbl_oe), .base_clk_o(base_clk),
    .base_oe_o(base_oe), .binv_clk_o(binv_clk), .binv_oe_o(binv_oe),
    .half_clk_o(half_clk), .half_oe_o(half_oe), .lock_o(lock_out)
  );

  int n_checks = 0;
  int n_err    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit near(input int cnt, input int per);
    return (cnt * per >= WIN_NS - per) && (cnt * per <= WIN_NS + per);
  endfunction

  // Scoreboard item: what one measurement window must show.
  typedef struct {
    string tag;
    int    src_per;
    bit    full;
  } exp_t;
  exp_t exp_q[$];
  event win_go, win_done;

  // Monitor state
  int c_dbl, c_base, c_half, bad_eq, bad_inv, bad_al, bad_half, bad_oe;
  logic p_dbl, p_b, p_h, act;

  initial begin : monitor
    exp_t it;
    int dper;
    forever begin
      @(win_go);
      c_dbl = 0; c_base = 0; c_half = 0;
      bad_eq = 0; bad_inv = 0; bad_al = 0; bad_half = 0; bad_oe = 0;
      p_dbl = dbl_clk; p_b = base_clk[0]; p_h = half_clk;
      act = osc_en;
      for (int i = 0; i < WIN_NS; i++) begin
        #1;
        if (dbl_clk && !p_dbl)     c_dbl++;
        if (base_clk[0] && !p_b)   c_base++;
        if (half_clk && !p_h)      c_half++;
        if (base_clk != {NB{base_clk[0]}}) bad_eq++;
        if (binv_clk == base_clk[0])       bad_inv++;
        if ((base_clk[0] != p_b) && !((dbl_clk != p_dbl) && (dbl_clk == act))) bad_al++;
        if ((half_clk != p_h) && !((base_clk[0] != p_b) && (base_clk[0] == act))) bad_half++;
        if (!(&{dbl_oe, base_oe, binv_oe, half_oe})) bad_oe++;
        p_dbl = dbl_clk; p_b = base_clk[0]; p_h = half_clk;
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "scoreboard empty", 0, 1);
      end else begin
        it = exp_q.pop_front();
        dper = it.src_per * (it.full ? 1 : 2);
        chk(near(c_dbl, dper), it.tag, "double-rate edges", c_dbl, WIN_NS / dper);
        chk(near(c_base, 2 * dper), "R4", "base edges", c_base, WIN_NS / (2 * dper));
        chk(near(c_half, 4 * dper), "R5", "half edges", c_half, WIN_NS / (4 * dper));
        chk(bad_eq == 0, "R4", "base outputs differ", bad_eq, 0);
        chk(bad_inv == 0, "R6", "inverted not complement", bad_inv, 0);
        chk(bad_al == 0, "R4", "base change off double-rate edge", bad_al, 0);
        chk(bad_half == 0, "R5", "half change off base edge", bad_half, 0);
        chk(bad_oe == 0, "R8", "enable low while pin high", bad_oe, 0);
      end
      -> win_done;
    end
  end

  // Driver: set a mode, let it settle, push the expectation, run a window.
  task automatic run_mode(input bit oscm, input bit sel, input bit full,
                          input string tag);
    exp_t it;
    osc_en = oscm; ref_sel = sel; rate_full = full;
    #600;
    it.tag     = tag;
    it.src_per = oscm ? OSC_P : (sel ? REF1_P : REF0_P);
    it.full    = full;
    exp_q.push_back(it);
    -> win_go;
    @(win_done);
  endtask

  // Hold in reset, check rest levels, release and check first edges.
  task automatic hold_reset(input bit oscm);
    int   bad = 0;
    bit   found = 1'b0;
    logic pb, pd, ph;
    oe_rst_n = 1'b0; osc_en = oscm;
    #1;
    chk({dbl_oe, base_oe, binv_oe, half_oe} == '0, "R8", "enables in reset",
        int'({dbl_oe, base_oe, binv_oe, half_oe}), 0);
    chk(base_clk == {NB{!oscm}}, "R7", "base rest level", int'(base_clk[0]), int'(!oscm));
    chk(binv_clk == oscm, "R7", "inverted rest level", int'(binv_clk), int'(oscm));
    chk(half_clk == !oscm, "R7", "half rest level", int'(half_clk), int'(!oscm));
    for (int i = 0; i < 300; i++) begin
      #1;
      if (base_clk != {NB{!oscm}} || binv_clk != oscm || half_clk != !oscm) bad++;
    end
    chk(bad == 0, "R8", "outputs moved while held", bad, 0);
    pb = base_clk[0]; pd = dbl_clk; ph = half_clk;
    oe_rst_n = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      #1;
      if (i == 0)
        chk(&{dbl_oe, base_oe, binv_oe, half_oe}, "R8", "enables after release", 0, 1);
      if (base_clk[0] != pb) begin
        found = 1'b1;
        chk(base_clk[0] == oscm, "R9", "first base level", int'(base_clk[0]), int'(oscm));
        chk((dbl_clk != pd) && (dbl_clk == oscm), "R9", "double-rate edge at release",
            int'(dbl_clk), int'(oscm));
        chk((half_clk != ph) && (half_clk == oscm), "R9", "first half edge",
            int'(half_clk), int'(oscm));
        break;
      end
      pb = base_clk[0]; pd = dbl_clk; ph = half_clk;
    end
    chk(found, "R9", "base started after release", int'(found), 1);
  endtask

  initial begin : watchdog
    #300000;
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : stim
    oe_rst_n = 1'b1; osc_en = 1'b1; ref_sel = 1'b0; rate_full = 1'b1; lock_in = 1'b0;
    #0.5;
    oe_rst_n = 1'b0;
    #20;
    // R8 / R7 reset state
    chk({dbl_oe, base_oe, binv_oe, half_oe} == '0, "R8", "enables at start",
        int'({dbl_oe, base_oe, binv_oe, half_oe}), 0);
    chk(base_clk == '0 && binv_clk && !half_clk, "R7", "start levels",
        int'({base_clk, binv_clk, half_clk}), 2);
    hold_reset(1'b1);
    run_mode(1'b1, 1'b0, 1'b1, "R2 R3 osc full");
    run_mode(1'b1, 1'b1, 1'b0, "R2 R3 osc half");
    run_mode(1'b0, 1'b0, 1'b1, "R1 R2 ref0 full");
    run_mode(1'b0, 1'b1, 1'b1, "R1 R2 ref1 full");
    run_mode(1'b0, 1'b1, 1'b0, "R1 R3 ref1 half");
    run_mode(1'b0, 1'b0, 1'b0, "R1 R3 ref0 half");
    hold_reset(1'b0);
    run_mode(1'b0, 1'b0, 1'b1, "R1 ref0 after bypass release");
    hold_reset(1'b1);
    run_mode(1'b1, 1'b0, 1'b0, "R3 osc half after release");
    // R10 lock pass-through
    lock_in = 1'b1; osc_en = 1'b1; #1;
    chk(lock_out == 1'b1, "R10", "lock normal", int'(lock_out), 1);
    osc_en = 1'b0; #1;
    chk(lock_out == 1'b0, "R10", "lock in bypass", int'(lock_out), 0);
    osc_en = 1'b1; lock_in = 1'b0; #1;
    chk(lock_out == 1'b0, "R10", "lock low", int'(lock_out), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule